// File: doc/BRIEF.md
# Multicycle Controller with Buffered Branch Target

This block is a small multicycle processor core that executes a reduced load/store instruction subset: word load, word store, register-to-register arithmetic and branch-on-equal. One memory port serves both instruction fetch and data access. An address-select signal decides each cycle whether the program counter or the latched ALU result drives the address. There is no separate program-counter adder. The single ALU is time-shared, so it first advances the program counter, then forms branch targets and effective addresses, then does arithmetic and comparisons.

The control state machine steps every instruction through a fixed sequence of states, and each sequence returns to the fetch state. A branch always runs the same three steps. First the fetch advances the program counter by four. Next the decode step forms the branch target from the advanced counter and latches it into a dedicated target register. Last the compare step subtracts the two source registers, and the core loads the program counter from the target register only if the two are equal. The memory itself lives outside the block and is read combinationally.

Top module: `mc_cpu`

## Requirements
- R1: While reset is high and in the cycle that follows it, the program counter is 0, the address select is 0 (instruction side), no memory write is requested and all 32 registers hold 0.
- R2: In the fetch state the address select is 0 and the memory address equals the program counter. Every instruction's fetch cycle ends with the program counter increased by 4.
- R3: The instruction register loads only in the fetch state. A data word read by a load, even one that encodes an instruction, never changes the instruction being executed.
- R4: Opcode 0x23 (bits 31:26) loads the word at register[bits 25:21] plus the sign-extended bits 15:0 into register[bits 20:16]. The address select is 1 during the data read, and the load takes 5 cycles.
- R5: Opcode 0x2B writes register[bits 20:16] to address register[bits 25:21] plus the sign-extended bits 15:0 and takes 4 cycles. A write is requested only while the address select is 1.
- R6: Opcode 0x00 writes register[bits 15:11] with the result of register[bits 25:21] and register[bits 20:16] combined by bits 5:0. The codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A signed less-than (result 1 or 0). It takes 4 cycles.
- R7: Register 0 always reads 0, and writes to it are discarded.
- R8: Opcode 0x04 takes 3 cycles. When the two source registers are equal, the next program counter is the fetch address plus 4 plus the sign-extended bits 15:0 times 4. Otherwise it is the fetch address plus 4.
- R9: The program counter changes only at the end of the fetch state and the branch compare state.
- R10: Any other opcode does nothing and takes 2 cycles: no register or memory changes.
- R11: Every instruction's last state is followed by the fetch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 32 | Combinational read data from the unified memory |
| mem_addr | output | 32 | Byte address to the unified memory |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write request for the current cycle |
| iord | output | 1 | Address select: 0 program counter, 1 latched ALU result |
| pc_out | output | 32 | Current program counter |

## Verification
On every cycle the checker confirms several behaviours of the state machine itself. It checks the fetch-side address selection, the plus-four advance after each fetch and the instruction register's stability outside fetch. It also checks that writes occur only on the data side, that the program counter holds still in every state but two, and that each final state hands over to fetch. The arithmetic results, the sign extension of addresses and offsets, the taken and not-taken branch targets, register zero and the per-instruction cycle counts show only at the memory port and the program counter after whole instruction sequences. Only the bench's sweeps over operand values, function codes and branch offsets can show them.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RA_W   = $clog2(NREGS);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MADDR,
        ST_MREAD,
        ST_MWB,
        ST_MWRITE,
        ST_EXEC,
        ST_RWB,
        ST_BRCMP
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef enum logic {
        SRCA_PC,
        SRCA_REG
    } srca_e;

    typedef enum logic [1:0] {
        SRCB_REG,
        SRCB_FOUR,
        SRCB_IMM,
        SRCB_IMM_SH
    } srcb_e;

    typedef struct packed {
        logic    iord;
        logic    pc_write;
        logic    pc_from_target;
        logic    branch;
        logic    target_write;
        logic    ir_write;
        logic    mdr_write;
        logic    aluout_write;
        logic    reg_write;
        logic    dst_is_rd;
        logic    wb_from_mem;
        logic    mem_we;
        srca_e   srca;
        srcb_e   srcb;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alu_op_e funct_to_op(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output state_e     state,
    output ctrl_t      ctl
);
    state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_LOAD, OP_STORE: nxt = ST_MADDR;
                    OP_RTYPE:          nxt = ST_EXEC;
                    OP_BEQ:            nxt = ST_BRCMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_MADDR:  nxt = (opcode == OP_LOAD) ? ST_MREAD : ST_MWRITE;
            ST_MREAD:  nxt = ST_MWB;
            ST_EXEC:   nxt = ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.srca   = SRCA_REG;
        ctl.srcb   = SRCB_REG;
        ctl.alu_op = ALU_ADD;
        case (state)
            ST_FETCH: begin
                ctl.ir_write = 1'b1;
                ctl.pc_write = 1'b1;
                ctl.srca     = SRCA_PC;
                ctl.srcb     = SRCB_FOUR;
            end
            ST_DECODE: begin
                ctl.target_write = 1'b1;
                ctl.srca         = SRCA_PC;
                ctl.srcb         = SRCB_IMM_SH;
            end
            ST_MADDR: begin
                ctl.aluout_write = 1'b1;
                ctl.srcb         = SRCB_IMM;
            end
            ST_MREAD: begin
                ctl.iord      = 1'b1;
                ctl.mdr_write = 1'b1;
            end
            ST_MWB: begin
                ctl.reg_write   = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_MWRITE: begin
                ctl.iord   = 1'b1;
                ctl.mem_we = 1'b1;
            end
            ST_EXEC: begin
                ctl.aluout_write = 1'b1;
                ctl.alu_op       = funct_to_op(funct);
            end
            ST_RWB: begin
                ctl.reg_write = 1'b1;
                ctl.dst_is_rd = 1'b1;
            end
            ST_BRCMP: begin
                ctl.branch         = 1'b1;
                ctl.pc_from_target = 1'b1;
                ctl.alu_op         = ALU_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_pkg::*;
#(
    parameter logic [XLEN-1:0] PC_RESET = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    output logic            iord,
    output logic [XLEN-1:0] pc_out
);
    state_e          state;
    ctrl_t           ctl;
    logic [XLEN-1:0] pc_q, target_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_y, imm, wb_data;
    logic [RA_W-1:0] wb_addr;
    logic            alu_zero, pc_we;

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[31:26]),
        .funct  (ir_q[5:0]),
        .state  (state),
        .ctl    (ctl)
    );

    assign imm     = sext16(ir_q[15:0]);
    assign wb_addr = ctl.dst_is_rd ? ir_q[15:11] : ir_q[20:16];
    assign wb_data = ctl.wb_from_mem ? mdr_q : aluout_q;

    mc_regfile #(.N(NREGS), .W(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q[25:21]),
        .ra2 (ir_q[20:16]),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (ctl.reg_write),
        .wa  (wb_addr),
        .wd  (wb_data)
    );

    always_comb begin
        alu_a = (ctl.srca == SRCA_PC) ? pc_q : a_q;
        case (ctl.srcb)
            SRCB_FOUR:   alu_b = XLEN'(4);
            SRCB_IMM:    alu_b = imm;
            SRCB_IMM_SH: alu_b = {imm[XLEN-3:0], 2'b00};
            default:     alu_b = b_q;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .op   (ctl.alu_op),
        .a    (alu_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign pc_we = ctl.pc_write | (ctl.branch & alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= PC_RESET;
            target_q <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_we)            pc_q     <= ctl.pc_from_target ? target_q : alu_y;
            if (ctl.target_write) target_q <= alu_y;
            if (ctl.ir_write)     ir_q     <= mem_rdata;
            if (ctl.mdr_write)    mdr_q    <= mem_rdata;
            if (ctl.aluout_write) aluout_q <= alu_y;
            if (state == ST_DECODE) begin
                a_q <= rd1;
                b_q <= rd2;
            end
        end
    end

    assign iord      = ctl.iord;
    assign mem_addr  = ctl.iord ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;
    assign pc_out    = pc_q;
endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk
    import mc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            iord,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] pc_out,
    input state_e          state,
    input logic [XLEN-1:0] ir
);
    logic rst_d = 1'b0;

    always @(posedge clk) rst_d <= rst;

    always @(negedge clk) begin
        if (rst_d) begin
            // R1
            pc_reset_chk: assert (pc_out == '0 && !mem_we && !iord && state == ST_FETCH)
                else $error("pc_reset_chk");
        end
    end

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |-> (!iord && mem_addr == pc_out));

    // R2
    fetch_incr_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> pc_out == $past(pc_out) + XLEN'(4));

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        state != ST_FETCH |=> $stable(ir));

    // R5
    write_side_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> iord);

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH && state != ST_BRCMP) |=> $stable(pc_out));

    // R11
    to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MWB || state == ST_MWRITE || state == ST_RWB || state == ST_BRCMP)
        |=> state == ST_FETCH);
endmodule

bind mc_cpu mc_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .iord     (iord),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .pc_out   (pc_out),
    .state    (state),
    .ir       (ir_q)
);

// File: tb/mc_cpu_test.sv
`timescale 1ns/1ps
module mc_cpu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, pc_out;
    logic        mem_we, iord;

    logic [31:0] mem [256];
    int          wcount = 0;
    int          checks = 0;
    int          fails  = 0;

    localparam logic [31:0] VALS [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF,
                                         32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    localparam logic [5:0] FNS [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    localparam int OFFS [7] = '{-3, -2, -1, 0, 1, 2, 7};

    always #2.5 clk = ~clk;

    mc_cpu uut (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .iord      (iord),
        .pc_out    (pc_out)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wcount <= wcount + 1;
        end
    end

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] model_alu(input logic [5:0] fn, input logic [31:0] a,
                                              input logic [31:0] b);
        case (fn)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
    endtask

    task automatic release_run(input int n);
        repeat (2) @(posedge clk);
        @(negedge clk);
        wcount = 0;
        rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: state during and right after reset
        hold_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc", pc_out, 32'h0);
        check("R1 iord", {31'b0, iord}, 32'h0);
        check("R1 we", {31'b0, mem_we}, 32'h0);
        check("R2 fetch addr", mem_addr, 32'h0);

        // R6 R4 R5 R2: function sweep over operand pairs
        foreach (FNS[f]) begin
            foreach (VALS[i]) begin
                foreach (VALS[j]) begin
                    hold_reset();
                    mem[0]  = enc_i(6'h23, 0, 1, 32'h100);
                    mem[1]  = enc_i(6'h23, 0, 2, 32'h104);
                    mem[2]  = enc_r(1, 2, 3, FNS[f]);
                    mem[3]  = enc_i(6'h2B, 0, 3, 32'h108);
                    mem[64] = VALS[i];
                    mem[65] = VALS[j];
                    release_run(18);
                    check("R6 result", mem[66], model_alu(FNS[f], VALS[i], VALS[j]));
                    check("R2 pc after 4 instr (R4 R5 R6 cycles)", pc_out, 32'd16);
                    check("R5 write count", wcount, 1);
                end
            end
        end

        // R7: register 0 ignores writes and reads as zero
        hold_reset();
        mem[0]  = enc_i(6'h23, 0, 1, 32'h100);
        mem[1]  = enc_r(1, 1, 0, 6'h20);
        mem[2]  = enc_r(0, 1, 3, 6'h20);
        mem[3]  = enc_i(6'h2B, 0, 3, 32'h108);
        mem[64] = 32'h0000_0055;
        release_run(17);
        check("R7 r0 stays zero", mem[66], 32'h0000_0055);
        check("R7 pc", pc_out, 32'd16);

        // R4 R3: negative displacement, loaded word encodes a store
        hold_reset();
        mem[0]  = enc_i(6'h23, 0, 5, 32'h100);
        mem[1]  = enc_i(6'h23, 5, 1, -4);
        mem[2]  = enc_i(6'h2B, 0, 1, 32'h108);
        mem[64] = 32'h0000_0110;
        mem[67] = enc_i(6'h2B, 0, 0, 32'h0);
        release_run(14);
        check("R4 negative displacement", mem[66], enc_i(6'h2B, 0, 0, 32'h0));
        check("R3 loaded data not executed", wcount, 1);
        check("R3 program 0 untouched", mem[0], enc_i(6'h23, 0, 5, 32'h100));
        check("R4 pc", pc_out, 32'd12);

        // R8: branch offsets, equal and unequal operands
        foreach (OFFS[k]) begin
            for (int eq = 0; eq < 2; eq++) begin
                hold_reset();
                mem[0]  = enc_i(6'h23, 0, 1, 32'h100);
                mem[1]  = enc_i(6'h23, 0, 2, 32'h104);
                mem[2]  = enc_i(6'h04, 1, 2, OFFS[k]);
                mem[64] = 32'h8000_0003;
                mem[65] = (eq == 1) ? 32'h8000_0003 : 32'h0000_0003;
                release_run(13);
                check("R8 branch pc", pc_out,
                      (eq == 1) ? 32'(12 + 4 * OFFS[k]) : 32'd12);
                check("R8 no write", wcount, 0);
            end
        end

        // R10: unknown opcode leaves registers and memory alone
        hold_reset();
        mem[0] = {6'h3F, 5'd1, 5'd1, 5'd3, 5'd0, 6'h20};
        mem[1] = enc_i(6'h2B, 0, 3, 32'h108);
        release_run(2);
        check("R10 two cycles", pc_out, 32'd4);
        check("R10 no write", wcount, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10 r3 untouched", mem[66], 32'h0);
        check("R10 pc after store", pc_out, 32'd8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule